// File: doc/BRIEF.md
# Tape Selection and Block Read Sequencer

This block is the control core of a virtual cassette player whose storage medium carries no file system. Tape images sit back to back on the medium, and each one starts on a fixed boundary of 32 storage blocks. The block keeps a tape index that a user steps with next and previous buttons. It keeps a play/stop state that a play button toggles. While the player is stopped, the block holds the downstream byte streamer in reset.

While playing, every block request from the streamer becomes a single-cycle read command to the storage controller. The block number on that command is the tape index times 32 plus a per-tape block counter. The storage controller ignores commands for a short time after each read. For this reason a request is held pending until the controller reports it is not busy, so that two requests arriving back to back never lose a block. Bytes that come back from storage are passed straight through to the streamer with their strobe.

The button inputs are assumed to be debounced single-cycle pulses. The storage controller and the display decoding are outside this block.

Top module: `tape_seq_top`

## Requirements
- R1: After reset the player is stopped, the tape index is 0, the streamer reset output is high and no read command is issued.
- R2: While stopped, a next pulse raises the tape index by one, and it wraps from TAPE_COUNT-1 to 0. A previous pulse lowers the index by one, and it wraps from 0 to TAPE_COUNT-1. Both pulses in the same cycle leave the index unchanged. The new index is visible one cycle after the pulse.
- R3: While playing, next and previous pulses are ignored and the tape index does not change.
- R4: Each play pulse toggles the player between stopped and playing, one cycle later. The streamer reset output is high exactly while the player is stopped.
- R5: The block number on a read command equals tape_index*BLOCKS_PER_TAPE + n. Here n counts the reads issued since play last started or the tape last changed, modulo BLOCKS_PER_TAPE.
- R6: A read command (sd_rd high for one cycle) is issued only in a cycle where sd_busy is low. A pending request is issued in the first such cycle, starting with the cycle after the request pulse.
- R7: At most one request is held pending. A request that arrives in the same cycle as an issued read becomes the new pending request. Requests made while stopped are ignored, and stopping discards a pending request.
- R8: While playing, storage bytes and their strobe reach the streamer unchanged in the same cycle. While stopped, the strobe to the streamer stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_play | input | 1 | Play/stop toggle pulse |
| btn_next | input | 1 | Next tape pulse |
| btn_prev | input | 1 | Previous tape pulse |
| strm_need | input | 1 | Block request pulse from the streamer |
| sd_busy | input | 1 | Storage controller cannot accept a command |
| sd_byte_valid | input | 1 | Storage byte strobe |
| sd_byte | input | 8 | Storage byte |
| sd_rd | output | 1 | Read command, one cycle per block |
| sd_blk | output | BLK_W | Absolute block number for the read |
| strm_rst | output | 1 | Reset to the streamer |
| strm_byte_valid | output | 1 | Byte strobe to the streamer |
| strm_byte | output | 8 | Byte to the streamer |
| play_on | output | 1 | Player is playing |
| tape_idx | output | IDX_W | Selected tape for the display |

## Verification
Button effects on the index and on the play state are registered, so they are due one cycle after the pulse. The bench samples them on the falling edge that follows. A request pulse sets the pending flag at the next rising edge. From then on sd_rd and sd_blk depend only on that flag and sd_busy, so the bench reads them 1 ns after the falling edge of the next cycle. It confirms that the read is gone one cycle later. Byte forwarding is combinational, so the bench checks it 1 ns after driving the strobe, within the same cycle.

// File: rtl/tape_seq_pkg.sv
package tape_seq_pkg;

  // step up with wrap inside [0, n)
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // step down with wrap inside [0, n)
  function automatic int unsigned wrap_dec(int unsigned v, int unsigned n);
    return (v == 0) ? n - 1 : v - 1;
  endfunction

  // absolute storage block of block 'cnt' within tape 'idx'
  function automatic int unsigned blk_addr(int unsigned idx, int unsigned cnt,
                                           int unsigned per_tape);
    return idx * per_tape + cnt;
  endfunction

endpackage

// File: rtl/tape_sel.sv
module tape_sel
  import tape_seq_pkg::*;
#(
  parameter int TAPE_COUNT = 16,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [IDX_W-1:0] idx,
  output logic             chg
);

  logic [IDX_W-1:0] idx_n;

  always_comb begin
    idx_n = idx;
    chg   = 1'b0;
    if (en && (step_up ^ step_dn)) begin
      chg   = 1'b1;
      idx_n = step_up ? IDX_W'(wrap_inc(int'(idx), TAPE_COUNT))
                      : IDX_W'(wrap_dec(int'(idx), TAPE_COUNT));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_n;
  end

endmodule

// File: rtl/play_ctl.sv
module play_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  output logic on,
  output logic start
);

  assign start = toggle && !on;

  always_ff @(posedge clk) begin
    if (!rst_n)      on <= 1'b0;
    else if (toggle) on <= !on;
  end

endmodule

// File: rtl/rd_gate.sv
module rd_gate
  import tape_seq_pkg::*;
#(
  parameter int BLOCKS = 32,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             clr,
  input  logic             need,
  input  logic             busy,
  output logic             pending,
  output logic             issue,
  output logic [CNT_W-1:0] cnt
);

  logic pending_n;

  assign issue = pending && !busy && active;

  always_comb begin
    if (!active)   pending_n = 1'b0;
    else if (need) pending_n = 1'b1;
    else if (issue) pending_n = 1'b0;
    else           pending_n = pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else begin
      pending <= pending_n;
      if (clr)        cnt <= '0;
      else if (issue) cnt <= CNT_W'(wrap_inc(int'(cnt), BLOCKS));
    end
  end

endmodule

// File: rtl/tape_seq_top.sv
module tape_seq_top
  import tape_seq_pkg::*;
#(
  parameter int TAPE_COUNT      = 16,
  parameter int BLOCKS_PER_TAPE = 32,
  parameter int BLK_W           = 32,
  localparam int IDX_W = (TAPE_COUNT > 1) ? $clog2(TAPE_COUNT) : 1,
  localparam int CNT_W = (BLOCKS_PER_TAPE > 1) ? $clog2(BLOCKS_PER_TAPE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_play,
  input  logic             btn_next,
  input  logic             btn_prev,
  input  logic             strm_need,
  input  logic             sd_busy,
  input  logic             sd_byte_valid,
  input  logic [7:0]       sd_byte,
  output logic             sd_rd,
  output logic [BLK_W-1:0] sd_blk,
  output logic             strm_rst,
  output logic             strm_byte_valid,
  output logic [7:0]       strm_byte,
  output logic             play_on,
  output logic [IDX_W-1:0] tape_idx
);

  // named internal events
  logic             play_start;
  logic             tape_chg;
  logic             rd_issue;
  logic             rd_pending;
  logic [CNT_W-1:0] blk_cnt;

  play_ctl u_play (
    .clk    (clk),
    .rst_n  (rst_n),
    .toggle (btn_play),
    .on     (play_on),
    .start  (play_start)
  );

  tape_sel #(.TAPE_COUNT(TAPE_COUNT), .IDX_W(IDX_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (!play_on),
    .step_up (btn_next),
    .step_dn (btn_prev),
    .idx     (tape_idx),
    .chg     (tape_chg)
  );

  rd_gate #(.BLOCKS(BLOCKS_PER_TAPE), .CNT_W(CNT_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (play_on),
    .clr     (play_start || tape_chg),
    .need    (strm_need),
    .busy    (sd_busy),
    .pending (rd_pending),
    .issue   (rd_issue),
    .cnt     (blk_cnt)
  );

  assign sd_rd           = rd_issue;
  assign sd_blk          = BLK_W'(blk_addr(int'(tape_idx), int'(blk_cnt), BLOCKS_PER_TAPE));
  assign strm_rst        = !play_on;
  assign strm_byte_valid = sd_byte_valid && play_on;
  assign strm_byte       = sd_byte;

endmodule

// File: rtl/tape_seq_chk.sv
module tape_seq_chk #(
  parameter int TAPE_COUNT      = 16,
  parameter int BLOCKS_PER_TAPE = 32,
  parameter int BLK_W           = 32,
  parameter int IDX_W           = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             btn_play,
  input logic             btn_next,
  input logic             btn_prev,
  input logic             sd_busy,
  input logic             sd_byte_valid,
  input logic             sd_rd,
  input logic [BLK_W-1:0] sd_blk,
  input logic             strm_byte_valid,
  input logic             play_on,
  input logic [IDX_W-1:0] tape_idx,
  input logic             play_start
);

  a_r2_next_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!play_on && btn_next && !btn_prev) |=>
      int'(tape_idx) == (int'($past(tape_idx)) + 1) % TAPE_COUNT);

  a_r3_idx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    play_on |=> $stable(tape_idx));

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    btn_play |=> (play_on != $past(play_on)));

  a_r5_start_base: assert property (@(posedge clk) disable iff (!rst_n)
    play_start |=> int'(sd_blk) == int'(tape_idx) * BLOCKS_PER_TAPE);

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_rd && play_on && !btn_play) |=>
      (int'(sd_blk) % BLOCKS_PER_TAPE) ==
      ((int'($past(sd_blk)) % BLOCKS_PER_TAPE) + 1) % BLOCKS_PER_TAPE);

  a_r6_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    sd_rd |-> !sd_busy);

  a_r7_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !play_on |-> !sd_rd);

  a_r8_gated_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strm_byte_valid |-> (sd_byte_valid && play_on));

endmodule

bind tape_seq_top tape_seq_chk #(
  .TAPE_COUNT(TAPE_COUNT), .BLOCKS_PER_TAPE(BLOCKS_PER_TAPE),
  .BLK_W(BLK_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/tape_seq_top_tb.sv
module tape_seq_top_tb;

  localparam int TC  = 5;
  localparam int BPT = 32;
  localparam int BW  = 32;
  localparam int IW  = $clog2(TC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_play = 0, btn_next = 0, btn_prev = 0, strm_need = 0;
  logic sd_busy = 0, sd_byte_valid = 0;
  logic [7:0] sd_byte = 8'h00;
  logic sd_rd, strm_rst, strm_byte_valid, play_on;
  logic [BW-1:0] sd_blk;
  logic [7:0] strm_byte;
  logic [IW-1:0] tape_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_idx = 0;
  int k = 0;

  always #10 clk = ~clk;

  tape_seq_top #(.TAPE_COUNT(TC), .BLOCKS_PER_TAPE(BPT), .BLK_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_play(btn_play), .btn_next(btn_next),
    .btn_prev(btn_prev), .strm_need(strm_need), .sd_busy(sd_busy),
    .sd_byte_valid(sd_byte_valid), .sd_byte(sd_byte), .sd_rd(sd_rd),
    .sd_blk(sd_blk), .strm_rst(strm_rst), .strm_byte_valid(strm_byte_valid),
    .strm_byte(strm_byte), .play_on(play_on), .tape_idx(tape_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // request one block and check the read that follows
  task automatic req_block(input string req);
    pulse(strm_need);
    chk(sd_rd == 1'b1, req, int'(sd_rd), 1);
    chk(int'(sd_blk) == exp_idx * BPT + (k % BPT), req, int'(sd_blk), exp_idx * BPT + (k % BPT));
    k++;
    @(negedge clk); #1;
    chk(sd_rd == 1'b0, req, int'(sd_rd), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(play_on == 1'b0, "R1 play", int'(play_on), 0);
    chk(tape_idx == '0, "R1 idx", int'(tape_idx), 0);
    chk(strm_rst == 1'b1, "R1 strm_rst", int'(strm_rst), 1);
    chk(sd_rd == 1'b0, "R1 sd_rd", int'(sd_rd), 0);

    // R2 next sweep with wrap
    for (int i = 0; i < 2 * TC + 2; i++) begin
      pulse(btn_next);
      exp_idx = (exp_idx + 1) % TC;
      chk(int'(tape_idx) == exp_idx, "R2 next", int'(tape_idx), exp_idx);
    end
    // R2 previous sweep with wrap
    for (int i = 0; i < 2 * TC + 2; i++) begin
      pulse(btn_prev);
      exp_idx = (exp_idx + TC - 1) % TC;
      chk(int'(tape_idx) == exp_idx, "R2 prev", int'(tape_idx), exp_idx);
    end
    // R2 both at once: no change
    @(negedge clk); btn_next = 1; btn_prev = 1;
    @(negedge clk); btn_next = 0; btn_prev = 0; #1;
    chk(int'(tape_idx) == exp_idx, "R2 both", int'(tape_idx), exp_idx);

    while (exp_idx != 3) begin
      pulse(btn_next);
      exp_idx = (exp_idx + 1) % TC;
    end

    // R7 request while stopped is ignored
    pulse(strm_need);
    chk(sd_rd == 1'b0, "R7 stopped need", int'(sd_rd), 0);
    @(negedge clk); #1;
    chk(sd_rd == 1'b0, "R7 stopped need later", int'(sd_rd), 0);

    // R8 strobe gated while stopped
    @(negedge clk); sd_byte_valid = 1; sd_byte = 8'h5A; #1;
    chk(strm_byte_valid == 1'b0, "R8 stopped strobe", int'(strm_byte_valid), 0);
    @(negedge clk); sd_byte_valid = 0;

    // R4 start playing
    pulse(btn_play);
    chk(play_on == 1'b1, "R4 play", int'(play_on), 1);
    chk(strm_rst == 1'b0, "R4 strm_rst low", int'(strm_rst), 0);

    // R3 selection ignored while playing
    pulse(btn_next);
    chk(int'(tape_idx) == exp_idx, "R3 next ignored", int'(tape_idx), exp_idx);
    pulse(btn_prev);
    chk(int'(tape_idx) == exp_idx, "R3 prev ignored", int'(tape_idx), exp_idx);

    // R5 R6 addresses across the per-tape wrap
    k = 0;
    for (int i = 0; i < BPT + 3; i++) req_block("R5 addr");

    // R6 held while busy, issued on first idle cycle
    @(negedge clk); sd_busy = 1;
    pulse(strm_need);
    for (int i = 0; i < 5; i++) begin
      chk(sd_rd == 1'b0, "R6 held busy", int'(sd_rd), 0);
      @(negedge clk); #1;
    end
    sd_busy = 0; #1;
    chk(sd_rd == 1'b1, "R6 idle issue", int'(sd_rd), 1);
    chk(int'(sd_blk) == exp_idx * BPT + (k % BPT), "R6 idle blk", int'(sd_blk), exp_idx * BPT + (k % BPT));
    k++;
    @(negedge clk); #1;
    chk(sd_rd == 1'b0, "R6 single cycle", int'(sd_rd), 0);

    // R7 request in the issuing cycle re-arms
    pulse(strm_need);
    chk(sd_rd == 1'b1, "R7 first", int'(sd_rd), 1);
    k++;
    strm_need = 1;
    @(negedge clk); strm_need = 0; #1;
    chk(sd_rd == 1'b1, "R7 rearm", int'(sd_rd), 1);
    chk(int'(sd_blk) == exp_idx * BPT + (k % BPT), "R7 rearm blk", int'(sd_blk), exp_idx * BPT + (k % BPT));
    k++;
    @(negedge clk); #1;
    chk(sd_rd == 1'b0, "R7 rearm done", int'(sd_rd), 0);

    // R8 forwarding while playing
    for (int b = 0; b < 256; b += 37) begin
      @(negedge clk); sd_byte_valid = 1; sd_byte = 8'(b); #1;
      chk(strm_byte_valid == 1'b1, "R8 strobe", int'(strm_byte_valid), 1);
      chk(int'(strm_byte) == b, "R8 byte", int'(strm_byte), b);
    end
    @(negedge clk); sd_byte_valid = 0;

    // R7 stop discards a pending request
    sd_busy = 1;
    pulse(strm_need);
    pulse(btn_play);
    chk(strm_rst == 1'b1, "R4 stopped reset", int'(strm_rst), 1);
    sd_busy = 0; #1;
    chk(sd_rd == 1'b0, "R7 discarded", int'(sd_rd), 0);
    @(negedge clk); #1;
    chk(sd_rd == 1'b0, "R7 discarded later", int'(sd_rd), 0);

    // R5 tape change and restart clear the counter
    pulse(btn_prev);
    exp_idx = (exp_idx + TC - 1) % TC;
    pulse(btn_play);
    k = 0;
    req_block("R5 cleared");
    req_block("R5 cleared next");
    pulse(btn_play);
    pulse(btn_play);
    k = 0;
    req_block("R5 restart");

    summary();
  end

endmodule